// File: doc/BRIEF.md
# Row-Buffered Multiplexed-Address DRAM Array

This block is a clocked behavioural model of a dynamic memory array. Its address reaches it in two halves over one shared bus. The row number is presented first and captured on the falling edge of an active-low row strobe. The column number follows on the same pins and is captured on the falling edge of an active-low column strobe. All strobes and data are sampled on the rising clock edge, and an edge means a change between two successive samples.

When a row is opened, every byte of that row is copied from the array into a row-wide buffer. Each column access then reads one byte out of that buffer or writes one byte into it. While the row strobe stays low, any number of column strobes can follow (page mode), and none of them touches the array. The buffer goes back into the array in the cycle the row strobe rises. Read data is flagged valid only while output enable is low, which stands in for a bus that would otherwise float.

The controller is a three-state machine:
- `ST_IDLE`: no row is open.
- `ST_OPEN`: a row is held in the buffer and the column strobe is high.
- `ST_ACCESS`: a column has been latched and the column strobe is held low.

Its transitions are:
- open: `ST_IDLE` to `ST_OPEN` on a row-strobe fall.
- column: `ST_OPEN` to `ST_ACCESS` on a column-strobe fall.
- release: `ST_ACCESS` to `ST_OPEN` when the column strobe goes high.
- close: `ST_OPEN` or `ST_ACCESS` to `ST_IDLE` whenever the row strobe is high.

The default row count is scaled down to 4 so that elaboration stays small. A full-size part has 12 row bits.

Top module: `mux_dram_array`

## Requirements
- R1: After reset the block is in `ST_IDLE`. `dout_vld` and `err` are 0, `dout` is 0, and every byte of the array is 0.
- R2: A row-strobe fall (`ras_n` 1 in the previous sample, 0 now) in `ST_IDLE` latches row `addr[ROW_BITS-1:0]`. Higher address bits are ignored, so 12'h801 selects row 1 when ROW_BITS is 2. The fall copies that row into the buffer.
- R3: A column-strobe fall while a row is open latches column `addr[COL_BITS-1:0]` (bits 8:0 by default). For a read with `oe_n` low, `dout` shows the selected byte and `dout_vld` is 1 from the first clock edge after the fall for as long as `cas_n` stays low.
- R4: While `oe_n` is high, `dout_vld` is 0 and `dout` is 0. Lowering `oe_n` during a held read access brings the data out with no new strobe.
- R5: When `we_n` is low at a column-strobe fall, the buffer byte at the latched column takes `din`. A write access never raises `dout_vld`.
- R6: Successive column strobes under one row-strobe low period read and write different bytes of the same row without reopening it, including columns 0 and 511.
- R7: When `ras_n` is high in `ST_OPEN` or `ST_ACCESS`, the buffer is written back to its row and the state returns to `ST_IDLE`. Other rows are unchanged.
- R8: Reads do not change stored data. Reading a byte repeatedly, across row closes and reopens, returns the same value.
- R9: A column-strobe fall in `ST_IDLE` changes no stored data, even with `we_n` low. It raises `err` for exactly one cycle, after the next clock edge.
- R10: If `ras_n` is high in the same sample as a column-strobe fall while a row is open, the close wins. The column access, including any write, is dropped and `err` stays 0.
- R11: A rising `cas_n` in `ST_ACCESS` with `ras_n` low returns to `ST_OPEN`, and `dout_vld` drops to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write select, sampled at the column-strobe fall |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W (12) | Shared row/column address bus |
| din | input | DATA_W (8) | Write data |
| dout | output | DATA_W (8) | Read data, 0 when not valid |
| dout_vld | output | 1 | Read data is being driven |
| err | output | 1 | One-cycle pulse: column strobe with no row open |

## Verification
The hardest situation to reach is a row strobe rising in the very sample in which the column strobe falls with a write pending. The priority rule of R10 can only be seen there, and only if the dropped byte is later read back from a reopened row. The bench drives that exact sample from an open row, then reopens the row and reads the target column to prove that nothing landed. A stray column strobe carrying write data to a byte that is already known, with no row open, is also built on purpose. A later read of that byte shows the array untouched, and the single-cycle error pulse is checked in the cycle after it.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_ACCESS = 2'd2
    } dram_st_e;

endpackage

// File: rtl/mux_dram_strobe.sv
// Edge finder for the two active-low strobes.
// A fall is a low sample that follows a high sample.
module mux_dram_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output logic ras_fall,
    output logic cas_fall
);

    logic ras_prev_q;
    logic cas_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_prev_q <= 1'b1;
            cas_prev_q <= 1'b1;
        end else begin
            ras_prev_q <= ras_n;
            cas_prev_q <= cas_n;
        end
    end

    assign ras_fall = ras_prev_q && !ras_n;
    assign cas_fall = cas_prev_q && !cas_n;

endmodule

// File: rtl/mux_dram_fsm.sv
// Sequencer: decides open, column, release and close.
// It also produces the read-valid flag and the protocol-error pulse.
module mux_dram_fsm
    import mux_dram_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     oe_n,
    input  logic     ras_fall,
    input  logic     cas_fall,
    output dram_st_e state,
    output logic     open_row,
    output logic     col_latch,
    output logic     col_write,
    output logic     writeback,
    output logic     rd_valid,
    output logic     proto_err
);

    dram_st_e state_q;
    dram_st_e state_d;
    logic     wr_q;
    logic     wr_d;
    logic     err_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            wr_q    <= wr_d;
            err_q   <= cas_fall && (state_q == ST_IDLE);
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        wr_d    = wr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ras_fall) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (ras_n) begin
                    state_d = ST_IDLE;
                end else if (cas_fall) begin
                    state_d = ST_ACCESS;
                    wr_d    = !we_n;
                end
            end
            ST_ACCESS: begin
                if (ras_n)      state_d = ST_IDLE;
                else if (cas_n) state_d = ST_OPEN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        open_row  = 1'b0;
        col_latch = 1'b0;
        col_write = 1'b0;
        writeback = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                open_row = ras_fall;
            end
            ST_OPEN: begin
                writeback = ras_n;
                col_latch = !ras_n && cas_fall;
                col_write = !ras_n && cas_fall && !we_n;
            end
            ST_ACCESS: begin
                writeback = ras_n;
            end
            default: begin
                open_row = 1'b0;
            end
        endcase
    end

    assign state     = state_q;
    assign rd_valid  = (state_q == ST_ACCESS) && !oe_n && !wr_q;
    assign proto_err = err_q;

endmodule

// File: rtl/mux_dram_store.sv
// Cell array, row buffer, and the row and column address latches.
module mux_dram_store #(
    parameter int ADDR_W   = 12,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 9,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              open_row,
    input  logic              col_latch,
    input  logic              col_write,
    input  logic              writeback,
    output logic [DATA_W-1:0] rd_byte
);

    localparam int NUM_ROWS = 1 << ROW_BITS;
    localparam int NUM_COLS = 1 << COL_BITS;
    localparam int ROW_W    = NUM_COLS * DATA_W;

    logic [ROW_W-1:0]    cells [NUM_ROWS];
    logic [ROW_W-1:0]    row_buf;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [ROW_BITS-1:0] row_sel;
    logic [COL_BITS-1:0] col_sel;
    int unsigned         wr_pos;
    int unsigned         rd_pos;
    logic                unused_addr_bits;

    assign row_sel          = addr[ROW_BITS-1:0];
    assign col_sel          = addr[COL_BITS-1:0];
    assign unused_addr_bits = ^addr;
    assign wr_pos           = 32'(col_sel) * 32'(DATA_W);
    assign rd_pos           = 32'(col_q) * 32'(DATA_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ROWS; i++) cells[i] <= '0;
            row_buf <= '0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            if (open_row) begin
                row_q   <= row_sel;
                row_buf <= cells[row_sel];
            end
            if (col_latch) begin
                col_q <= col_sel;
                if (col_write) row_buf[wr_pos +: DATA_W] <= din;
            end
            if (writeback) cells[row_q] <= row_buf;
        end
    end

    assign rd_byte = row_buf[rd_pos +: DATA_W];

endmodule

// File: rtl/mux_dram_array.sv
module mux_dram_array #(
    parameter int ADDR_W   = 12,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 9,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              err
);

    import mux_dram_pkg::*;

    logic              ras_fall;
    logic              cas_fall;
    dram_st_e          fsm_state;
    logic              open_row;
    logic              col_latch;
    logic              col_write;
    logic              writeback;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_byte;

    mux_dram_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .ras_fall (ras_fall),
        .cas_fall (cas_fall)
    );

    mux_dram_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .ras_fall  (ras_fall),
        .cas_fall  (cas_fall),
        .state     (fsm_state),
        .open_row  (open_row),
        .col_latch (col_latch),
        .col_write (col_write),
        .writeback (writeback),
        .rd_valid  (rd_valid),
        .proto_err (err)
    );

    mux_dram_store #(
        .ADDR_W   (ADDR_W),
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .din       (din),
        .open_row  (open_row),
        .col_latch (col_latch),
        .col_write (col_write),
        .writeback (writeback),
        .rd_byte   (rd_byte)
    );

    assign dout_vld = rd_valid;
    assign dout     = rd_valid ? rd_byte : '0;

endmodule

// File: rtl/mux_dram_array_chk.sv
module mux_dram_array_chk
    import mux_dram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld,
    input logic              err,
    input dram_st_e          state
);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> !oe_n);

    // R4
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));

    // R7
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && state != ST_IDLE) |=> (state == ST_IDLE && !dout_vld));

    // R10
    close_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && state != ST_IDLE) |=> !err);

    // R11
    cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && !ras_n && cas_n) |=> (state == ST_OPEN && !dout_vld));

    // R2
    row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ras_n && $past(ras_n)) |=> (state == ST_OPEN));

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && $past(dout_vld)) |-> $stable(dout));

    // R9
    idle_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !dout_vld);

endmodule

bind mux_dram_array mux_dram_array_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .oe_n     (oe_n),
    .dout     (dout),
    .dout_vld (dout_vld),
    .err      (err),
    .state    (fsm_state)
);

// File: tb/mux_dram_array_bench.sv
module mux_dram_array_bench;

    localparam int ADDR_W   = 12;
    localparam int ROW_BITS = 2;
    localparam int COL_BITS = 9;
    localparam int DATA_W   = 8;
    localparam int NROWS    = 1 << ROW_BITS;
    localparam int NCOLS    = 1 << COL_BITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1;
    logic              cas_n = 1'b1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_vld;
    logic              err;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    mux_dram_array #(
        .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)
    ) u_mux_dram_array (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: byte arrays, integer state code (0 idle, 1 open, 2 access)
    logic [7:0] m_mem [NROWS][NCOLS];
    logic [7:0] m_buf [NCOLS];
    int         m_st = 0;
    bit         m_wr = 0;
    bit         m_err = 0;
    int         m_row = 0;
    int         m_col = 0;
    bit         m_pras = 1;
    bit         m_pcas = 1;

    always @(posedge clk) begin
        bit rf;
        bit cf;
        bit e_vld;
        logic [7:0] e_dout;
        if (!rst_n) begin
            for (int r = 0; r < NROWS; r++)
                for (int c = 0; c < NCOLS; c++) m_mem[r][c] = 8'h00;
            for (int c = 0; c < NCOLS; c++) m_buf[c] = 8'h00;
            m_st = 0; m_wr = 0; m_err = 0; m_row = 0; m_col = 0;
            m_pras = 1; m_pcas = 1;
        end else begin
            cycles++;
            rf = m_pras && !ras_n;
            cf = m_pcas && !cas_n;
            m_err = cf && (m_st == 0);
            if (m_st == 0) begin
                if (rf) begin
                    m_row = int'(addr) % NROWS;
                    for (int c = 0; c < NCOLS; c++) m_buf[c] = m_mem[m_row][c];
                    m_st = 1;
                end
            end else if (ras_n) begin
                for (int c = 0; c < NCOLS; c++) m_mem[m_row][c] = m_buf[c];
                m_st = 0;
            end else if (m_st == 1) begin
                if (cf) begin
                    m_col = int'(addr) % NCOLS;
                    m_wr  = !we_n;
                    if (!we_n) m_buf[m_col] = din;
                    m_st = 2;
                end
            end else if (cas_n) begin
                m_st = 1;
            end
            m_pras = ras_n;
            m_pcas = cas_n;
            #2;
            e_vld  = (m_st == 2) && !oe_n && !m_wr;
            e_dout = e_vld ? m_buf[m_col] : 8'h00;
            check(dout_vld == e_vld, cur_req, "model dout_vld", int'(dout_vld), int'(e_vld));
            check(dout == e_dout, cur_req, "model dout", int'(dout), int'(e_dout));
            check(err == m_err, cur_req, "model err", int'(err), int'(m_err));
        end
    end

    task automatic open_row(input logic [ADDR_W-1:0] a);
        @(negedge clk); ras_n = 1'b0; addr = a;
    endtask

    task automatic close_row();
        @(negedge clk); ras_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_col(input int c, input logic [7:0] d, input string req);
        @(negedge clk); cas_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = ADDR_W'(c); din = d;
        @(posedge clk); #3;
        check(dout_vld == 1'b0, req, "write access must not drive data", int'(dout_vld), 0);
        @(negedge clk); cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_col(input int c, input logic [7:0] exp, input string req);
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b0; addr = ADDR_W'(c);
        @(posedge clk); #3;
        check(dout_vld == 1'b1, req, "read valid", int'(dout_vld), 1);
        check(dout == exp, req, "read data", int'(dout), int'(exp));
        @(negedge clk); cas_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); #3;
        check(dout_vld == 1'b0, req, "valid after cas rise", int'(dout_vld), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #3;
        // R1: reset state
        check(dout_vld == 1'b0 && err == 1'b0 && dout == 8'h00, "R1", "reset outputs",
              int'({dout_vld, err, dout}), 0);

        // R2 R3: open row 1, reset contents read as zero
        cur_req = "R3";
        open_row(12'h001);
        read_col(5, 8'h00, "R3");

        // R5 R6: page-mode writes and reads incl. column edges
        cur_req = "R6";
        write_col(5, 8'hA5, "R5");
        write_col(511, 8'h3C, "R6");
        write_col(0, 8'h11, "R6");
        read_col(5, 8'hA5, "R5");
        read_col(511, 8'h3C, "R6");
        read_col(0, 8'h11, "R6");

        // R4: output enable gating on a held read access
        cur_req = "R4";
        @(negedge clk); cas_n = 1'b0; oe_n = 1'b1; addr = 12'd5;
        @(posedge clk); #3;
        check(dout_vld == 1'b0 && dout == 8'h00, "R4", "oe high hides data",
              int'({dout_vld, dout}), 0);
        @(negedge clk); oe_n = 1'b0;
        #3;
        check(dout_vld == 1'b1 && dout == 8'hA5, "R4", "oe low shows data",
              int'({dout_vld, dout}), int'({1'b1, 8'hA5}));
        // R11: cas rise
        cur_req = "R11";
        @(negedge clk); cas_n = 1'b1;
        @(posedge clk); #3;
        check(dout_vld == 1'b0, "R11", "cas release drops valid", int'(dout_vld), 0);
        @(negedge clk); oe_n = 1'b1;

        // R7: write-back, other rows untouched
        cur_req = "R7";
        close_row();
        open_row(12'h002);
        read_col(5, 8'h00, "R7");
        close_row();
        // R2: high address bits ignored, 12'h801 selects row 1
        cur_req = "R2";
        open_row(12'h801);
        read_col(5, 8'hA5, "R7");
        read_col(5, 8'hA5, "R8");
        read_col(511, 8'h3C, "R2");
        close_row();
        // R8: reopen and read again
        cur_req = "R8";
        open_row(12'h001);
        read_col(5, 8'hA5, "R8");
        read_col(0, 8'h11, "R8");
        close_row();

        // R9: stray column strobe with a write, no row open
        cur_req = "R9";
        @(negedge clk); cas_n = 1'b0; we_n = 1'b0; addr = 12'd5; din = 8'hEE;
        @(posedge clk); #3;
        check(err == 1'b1, "R9", "stray cas raises err", int'(err), 1);
        @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
        @(posedge clk); #3;
        check(err == 1'b0, "R9", "err lasts one cycle", int'(err), 0);
        open_row(12'h001);
        read_col(5, 8'hA5, "R9");

        // R10: ras rise in the same sample as a cas fall with a write
        cur_req = "R10";
        @(negedge clk); ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b0; addr = 12'd6; din = 8'h77;
        @(posedge clk); #3;
        check(err == 1'b0, "R10", "no err on close priority", int'(err), 0);
        @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
        @(posedge clk); #3;
        check(err == 1'b0, "R10", "no err after close", int'(err), 0);
        @(negedge clk);
        open_row(12'h001);
        read_col(6, 8'h00, "R10");
        read_col(5, 8'hA5, "R10");
        close_row();

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule